// File: doc/BRIEF.md
# Indirection Prefix Tracking Unit

This unit sits beside the microsequencer of an 8-bit microcoded processor. One otherwise unused opcode serves as a one-byte addressing-mode prefix. When that opcode is fetched, the unit sets a hidden flag. The flag lives outside the architectural status byte, so a status push never exposes it. While the flag is set and the modified instruction has been fetched, the unit raises a branch condition. The microprogram uses it to jump into the indirect version of that instruction's addressing sequence. Examples are the test-and-set/reset-bits instructions in direct-page or absolute form, and the absolute subroutine call.

The flag covers exactly one following instruction. It clears at the instruction-boundary strobe that ends that instruction. The prefix and the instruction it modifies form one unit, so the interrupt gate refuses an interrupt at the boundary between them. When the decoder reports that the target opcode is already indirect, the branch condition stays low and the prefix has no effect.

Top module: `ind_prefix_unit`

## Requirements
- R1: After reset, `ind_flag_o`, `ind_branch_o` and `irq_inhibit_o` are all low.
- R2: A fetch (`fetch_i` high) of opcode `PREFIX_OP` (default 8'h0B) sets `ind_flag_o` and `irq_inhibit_o` from the next cycle on. This holds even when `sync_i` is high in the same cycle.
- R3: A fetch of any other opcode while the flag is clear leaves the flag and the branch condition low.
- R4: When the flag is set and no target is recorded, a fetch of a non-prefix opcode with `already_ind_i` low records it as the target. `ind_branch_o` is then high from the next cycle until the flag clears. `ind_branch_o` is never high while the flag is clear.
- R5: If `already_ind_i` is high at the target fetch, `ind_branch_o` stays low for that instruction, while the flag and the inhibit still behave as in R2 and R6.
- R6: `sync_i` clears the flag in the next cycle only once a target has been recorded. The boundary that ends the prefix itself leaves the flag set.
- R7: `irq_take_o` equals `irq_req_i && sync_i`, except that it is forced low while the flag is set and no target is recorded yet. It is combinational.
- R8: Consecutive prefixes keep the flag set, and the first non-prefix opcode after them becomes the target.
- R9: A non-prefix fetch that arrives after a target was recorded, without an intervening `sync_i`, clears the flag and the branch condition in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode_i | input | OP_W | Opcode byte on the fetch cycle |
| fetch_i | input | 1 | Opcode-fetch strobe |
| sync_i | input | 1 | Instruction-boundary strobe |
| already_ind_i | input | 1 | Fetched opcode already uses an indirect mode |
| irq_req_i | input | 1 | Pending interrupt request |
| ind_flag_o | output | 1 | Hidden indirection flag |
| ind_branch_o | output | 1 | Microprogram branch condition to the indirect sequence |
| irq_inhibit_o | output | 1 | Prefix pair in progress |
| irq_take_o | output | 1 | Interrupt may be recognised at this boundary |

## Verification
`irq_take_o` is combinational, so the bench checks it 1 ns after driving inputs on the falling edge, within the same cycle. The flag, branch and inhibit outputs come from one register stage. Their effect of a stimulus is due at the first rising edge, and the bench samples them 1 ns after that edge. The bench's model advances its state at the same edge, so every expected value refers to the cycle it is compared in.

// File: rtl/ind_prefix_pkg.sv
package ind_prefix_pkg;

    typedef struct packed {
        logic flag;     // hidden indirection flag
        logic tgt;      // modified instruction has been fetched
        logic tgt_ind;  // that instruction was already indirect
    } pfx_state_t;

    localparam pfx_state_t PFX_IDLE = '{flag: 1'b0, tgt: 1'b0, tgt_ind: 1'b0};

endpackage

// File: rtl/ind_prefix_match.sv
module ind_prefix_match #(
    parameter int              OP_W      = 8,
    parameter logic [OP_W-1:0] PREFIX_OP = 8'h0B
) (
    input  logic [OP_W-1:0] opcode_i,
    input  logic            fetch_i,
    output logic            pfx_fetch_o,
    output logic            other_fetch_o
);

    logic is_pfx;

    always_comb begin
        is_pfx        = (opcode_i == PREFIX_OP);
        pfx_fetch_o   = fetch_i && is_pfx;
        other_fetch_o = fetch_i && !is_pfx;
    end

endmodule

// File: rtl/ind_prefix_state.sv
module ind_prefix_state
    import ind_prefix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pfx_fetch_i,
    input  logic other_fetch_i,
    input  logic sync_i,
    input  logic already_ind_i,
    output logic flag_o,
    output logic tgt_o,
    output logic branch_o
);

    pfx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // boundary that ends a recorded target closes the pair
        if (sync_i && st_q.tgt) begin
            st_d = PFX_IDLE;
        end
        if (pfx_fetch_i) begin
            st_d.flag    = 1'b1;
            st_d.tgt     = 1'b0;
            st_d.tgt_ind = 1'b0;
        end else if (other_fetch_i) begin
            if (st_d.flag && !st_d.tgt) begin
                st_d.tgt     = 1'b1;
                st_d.tgt_ind = already_ind_i;
            end else begin
                st_d = PFX_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PFX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flag_o   = st_q.flag;
        tgt_o    = st_q.tgt;
        branch_o = st_q.flag && st_q.tgt && !st_q.tgt_ind;
    end

    AST_SET_ON_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_fetch_i |=> flag_o);  // R2
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && other_fetch_i) |=> (!flag_o && !branch_o));  // R3
    AST_CLEAR_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && tgt_o && !pfx_fetch_i) |=> !flag_o);  // R6
    AST_PREFIX_SYNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && flag_o && !tgt_o && !fetch_any()) |=> (flag_o && !tgt_o));  // R6

    function automatic logic fetch_any();
        return pfx_fetch_i || other_fetch_i;
    endfunction

endmodule

// File: rtl/ind_prefix_irq_gate.sv
module ind_prefix_irq_gate (
    input  logic flag_i,
    input  logic tgt_i,
    input  logic sync_i,
    input  logic irq_req_i,
    output logic irq_take_o
);

    logic pair_open;

    always_comb begin
        pair_open  = flag_i && !tgt_i;
        irq_take_o = irq_req_i && sync_i && !pair_open;
    end

endmodule

// File: rtl/ind_prefix_unit.sv
module ind_prefix_unit #(
    parameter int              OP_W      = 8,
    parameter logic [OP_W-1:0] PREFIX_OP = 8'h0B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            fetch_i,
    input  logic            sync_i,
    input  logic            already_ind_i,
    input  logic            irq_req_i,
    output logic            ind_flag_o,
    output logic            ind_branch_o,
    output logic            irq_inhibit_o,
    output logic            irq_take_o
);

    logic pfx_fetch, other_fetch, flag, tgt, branch;

    ind_prefix_match #(.OP_W(OP_W), .PREFIX_OP(PREFIX_OP)) u_match (
        .opcode_i      (opcode_i),
        .fetch_i       (fetch_i),
        .pfx_fetch_o   (pfx_fetch),
        .other_fetch_o (other_fetch)
    );

    ind_prefix_state u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .pfx_fetch_i   (pfx_fetch),
        .other_fetch_i (other_fetch),
        .sync_i        (sync_i),
        .already_ind_i (already_ind_i),
        .flag_o        (flag),
        .tgt_o         (tgt),
        .branch_o      (branch)
    );

    ind_prefix_irq_gate u_gate (
        .flag_i     (flag),
        .tgt_i      (tgt),
        .sync_i     (sync_i),
        .irq_req_i  (irq_req_i),
        .irq_take_o (irq_take_o)
    );

    always_comb begin
        ind_flag_o    = flag;
        ind_branch_o  = branch;
        irq_inhibit_o = flag;
    end

    AST_BRANCH_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ind_branch_o |-> ind_flag_o);  // R4
    AST_IND_TARGET_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && opcode_i != PREFIX_OP && ind_flag_o && !tgt && already_ind_i)
        |=> !ind_branch_o);  // R5
    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> (irq_req_i && sync_i));  // R7
    AST_NO_TAKE_MID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit_o && !tgt) |-> !irq_take_o);  // R7
    AST_STALE_TARGET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && opcode_i != PREFIX_OP && tgt && !sync_i) |=> !ind_flag_o);  // R9

endmodule

// File: tb/ind_prefix_unit_test.sv
module ind_prefix_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PFX = 8'h0B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic fetch_i = 1'b0, sync_i = 1'b0, already_ind_i = 1'b0, irq_req_i = 1'b0;
    logic ind_flag_o, ind_branch_o, irq_inhibit_o, irq_take_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model of the requirement-level state
    bit m_flag = 0, m_tgt = 0, m_tind = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_prefix_unit uut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .fetch_i(fetch_i),
        .sync_i(sync_i), .already_ind_i(already_ind_i), .irq_req_i(irq_req_i),
        .ind_flag_o(ind_flag_o), .ind_branch_o(ind_branch_o),
        .irq_inhibit_o(irq_inhibit_o), .irq_take_o(irq_take_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_take(bit req, bit syn);
        return req && syn && !(m_flag && !m_tgt);  // R7
    endfunction

    function automatic bit exp_branch();
        return m_flag && m_tgt && !m_tind;  // R4 / R5
    endfunction

    task automatic model_update(bit f, logic [7:0] op, bit s, bit ai);
        if (s && m_tgt) begin m_flag = 0; m_tgt = 0; m_tind = 0; end  // R6
        if (f && op == PFX) begin m_flag = 1; m_tgt = 0; m_tind = 0; end  // R2, R8
        else if (f) begin
            if (m_flag && !m_tgt) begin m_tgt = 1; m_tind = ai; end  // R4
            else begin m_flag = 0; m_tgt = 0; m_tind = 0; end       // R3, R9
        end
    endtask

    task automatic step(input string tag, input bit f, input logic [7:0] op,
                        input bit s, input bit ai, input bit rq);
        @(negedge clk);
        fetch_i = f; opcode_i = op; sync_i = s; already_ind_i = ai; irq_req_i = rq;
        #1;
        chk({tag, " R7 take"}, irq_take_o, exp_take(rq, s));
        @(posedge clk);
        model_update(f, op, s, ai);
        #1;
        chk({tag, " flag"}, ind_flag_o, m_flag);
        chk({tag, " inhibit"}, irq_inhibit_o, m_flag);
        chk({tag, " branch"}, ind_branch_o, exp_branch());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flag", ind_flag_o, 1'b0);
        chk("R1 branch", ind_branch_o, 1'b0);
        chk("R1 inhibit", irq_inhibit_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R3: plain instruction, no effect
        step("R3 plain", 1, 8'h20, 0, 0, 1);
        step("R3 plain sync", 0, 8'h00, 1, 0, 1);
        // R2, R6, R7: prefix, its own boundary keeps flag and masks irq
        step("R2 prefix", 1, PFX, 0, 0, 0);
        chk("R2 flag set", ind_flag_o, 1'b1);
        step("R6 R7 prefix sync", 0, 8'h00, 1, 0, 1);
        chk("R6 kept", ind_flag_o, 1'b1);
        // R4: target fetch, branch high
        step("R4 target", 1, 8'h0C, 0, 0, 0);
        chk("R4 branch", ind_branch_o, 1'b1);
        step("R4 hold", 0, 8'h00, 0, 0, 0);
        step("R6 R7 target sync", 0, 8'h00, 1, 0, 1);
        chk("R6 cleared", ind_flag_o, 1'b0);
        // R5: already indirect target
        step("R5 prefix", 1, PFX, 0, 0, 0);
        step("R5 target", 1, 8'h6C, 0, 1, 0);
        chk("R5 no branch", ind_branch_o, 1'b0);
        chk("R5 flag still", ind_flag_o, 1'b1);
        step("R5 sync", 0, 8'h00, 1, 0, 0);
        // R8: two prefixes
        step("R8 p1", 1, PFX, 0, 0, 0);
        step("R8 p2", 1, PFX, 1, 0, 1);
        step("R8 target", 1, 8'h04, 0, 0, 0);
        chk("R8 branch", ind_branch_o, 1'b1);
        // R9: missed boundary then another fetch
        step("R9 stale", 1, 8'hEA, 0, 0, 0);
        chk("R9 cleared", ind_flag_o, 1'b0);
        // R2: prefix fetched in a boundary cycle
        step("R2 sync+prefix", 1, PFX, 1, 0, 1);
        step("R2 after", 0, 8'h00, 1, 0, 0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit f, s, ai, rq;
            logic [7:0] op;
            f  = ($urandom % 3) == 0;
            s  = ($urandom % 3) == 0;
            ai = ($urandom % 4) == 0;
            rq = $urandom % 2;
            op = (($urandom % 3) == 0) ? PFX : 8'($urandom);
            step("RND R2 R4 R6 R9", f, op, s, ai, rq);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule